// File: doc/BRIEF.md
# HDLC D-Channel Frame Transmitter

This block turns bytes written by a host into a serial HDLC bit stream for a low-rate signalling channel. The host pushes bytes into a 32-entry transmit store, then issues a transmit command that hands everything written so far to the serializer. The serializer wraps the released bytes in 0x7E flags and inserts a 0 after every run of five 1s inside the frame. While nothing is released the line carries back-to-back flags. One bit moves per cycle in which the bit-clock enable is high.

A long frame can be sent in pieces. The host writes a chunk and issues a transmit command. When the ready interrupt shows room, it writes the next chunk and commands again. The last chunk is released with the end-of-frame command, and the frame then closes with a flag. If the released bytes run out before an end-of-frame command, the frame is aborted with a run of 1s and a sticky underrun bit is set. A reset command aborts a frame in flight in the same way, empties the store and clears the underrun bit.

Top module: `dch_frame_tx`

## Requirements
- R1: After reset, `tx_bit` is 1, `underrun` is 0 and `pool_irq` is 1.
- R2: While no byte is released, each `bit_en` pulse sends the next bit of a repeating flag 0x7E, least significant bit first. After reset the sequence is 0,1,1,1,1,1,1,0 and repeats.
- R3: Released bytes go out least significant bit first, after an opening flag. After an end-of-frame command the last byte is followed by a closing flag.
- R4: Inside a frame, a 0 is inserted after every five consecutive 1s of byte data, including before the closing flag. Flags are never stuffed.
- R5: A byte that is written is not sent until a transmit command (`cmd_xmit`) or an end-of-frame command (`cmd_end`) follows it. A frame continues without a break when more bytes are released before the earlier ones run out.
- R6: If a frame needs its next byte, none is released, and no end-of-frame command is pending, the block sends seven 1s and then idle flags. It also sets `underrun`, which stays 1 until a reset command.
- R7: A `cmd_reset` pulse empties the store and drops every unsent byte. It clears `underrun` in the next cycle. A frame being sent when it arrives ends with seven 1s followed by flags.
- R8: `pool_irq` is 1 exactly when at least 16 of the 32 entries are free.
- R9: A write into a full store (32 bytes held) is dropped.
- R10: `tx_bit` changes only after a cycle in which `bit_en` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One-cycle pulse that advances the serial line by one bit |
| wr_en | input | 1 | Write strobe for the transmit store |
| wr_data | input | 8 | Byte to store |
| cmd_xmit | input | 1 | Transmit command: release all stored bytes, frame stays open |
| cmd_end | input | 1 | End-of-frame command: release all stored bytes and close the frame after them |
| cmd_reset | input | 1 | Reset command: abort the frame in flight and empty the store |
| tx_bit | output | 1 | Serial line |
| pool_irq | output | 1 | Ready interrupt, high while the store has at least 16 free entries |
| underrun | output | 1 | Sticky underrun status |

## Verification
A wrong bit counter or stuffing counter shows on the line within one byte time (about ten `bit_en` pulses). It appears as a misplaced flag or as a run of six or seven 1s, which a receiver reads as a spurious frame end or abort. A wrong release count shows up either as a premature abort or as bytes sent that were never commanded. A wrong store pointer shows up as corrupted byte values in the decoded frame. Both appear within the frame that follows. The bench decodes the line with an independent receiver model, so each of these faults becomes a missing, extra or altered frame.

// File: rtl/dtx_pkg.sv
package dtx_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_DATA = 2'd1,
        S_ABRT = 2'd2
    } tx_st_e;

    localparam logic [7:0] FLAG_BYTE = 8'h7E;

    typedef struct packed {
        tx_st_e      st;
        logic [7:0]  sh;
        logic [3:0]  left;
        logic [2:0]  ones;
        logic        fl_ok;
        logic        eof;
        logic        tx;
        logic        urun;
    } fr_s;

endpackage

// File: rtl/dtx_fifo.sv
module dtx_fifo #(
    parameter int DEPTH = 32,
    parameter int ROOM  = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          pop,
    input  logic          release_i,
    output logic [7:0]    head,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] rel,
    output logic          room_ok
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic [CW-1:0] rel;
    } ptr_s;

    ptr_s       ptr_d, ptr_q;
    logic       do_wr;
    logic [7:0] mem [DEPTH];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ptr_d = ptr_q;
        do_wr = wr_en && !flush && (ptr_q.cnt != CW'(DEPTH));
        if (flush) begin
            ptr_d = '0;
        end else begin
            if (do_wr) ptr_d.wp = bump(ptr_q.wp);
            if (pop)   ptr_d.rp = bump(ptr_q.rp);
            ptr_d.cnt = ptr_q.cnt + CW'(do_wr) - CW'(pop);
            ptr_d.rel = release_i ? ptr_d.cnt : (ptr_q.rel - CW'(pop));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[ptr_q.wp] <= wr_data;
    end

    assign head    = mem[ptr_q.rp];
    assign cnt     = ptr_q.cnt;
    assign rel     = ptr_q.rel;
    assign room_ok = (ptr_q.cnt <= CW'(DEPTH - ROOM));

endmodule

// File: rtl/dtx_framer.sv
module dtx_framer
    import dtx_pkg::*;
#(
    parameter int ABORT_ONES = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       cmd_end,
    input  logic       cmd_reset,
    input  logic       avail,
    input  logic [7:0] head,
    output logic       pop,
    output logic       tx_bit,
    output logic       underrun
);
    fr_s fr_d, fr_q;

    always_comb begin
        fr_d = fr_q;
        pop  = 1'b0;
        if (cmd_reset) begin
            fr_d.eof  = 1'b0;
            fr_d.urun = 1'b0;
            if (fr_q.st == S_DATA) begin
                fr_d.st   = S_ABRT;
                fr_d.left = 4'(ABORT_ONES);
                fr_d.ones = '0;
            end
        end else if (bit_en) begin
            unique case (fr_q.st)
                S_IDLE: begin
                    if (fr_q.left != 4'd0) begin
                        fr_d.tx   = fr_q.sh[0];
                        fr_d.sh   = fr_q.sh >> 1;
                        fr_d.left = fr_q.left - 4'd1;
                        if (fr_q.left == 4'd1) fr_d.fl_ok = 1'b1;
                    end else if (fr_q.fl_ok && avail) begin
                        pop        = 1'b1;
                        fr_d.st    = S_DATA;
                        fr_d.tx    = head[0];
                        fr_d.sh    = head >> 1;
                        fr_d.left  = 4'd7;
                        fr_d.ones  = head[0] ? 3'd1 : 3'd0;
                        fr_d.fl_ok = 1'b0;
                    end else begin
                        if (!avail) fr_d.eof = 1'b0;
                        fr_d.tx   = FLAG_BYTE[0];
                        fr_d.sh   = FLAG_BYTE >> 1;
                        fr_d.left = 4'd7;
                    end
                end
                S_DATA: begin
                    if (fr_q.ones == 3'd5) begin
                        fr_d.tx   = 1'b0;
                        fr_d.ones = '0;
                    end else if (fr_q.left != 4'd0) begin
                        fr_d.tx   = fr_q.sh[0];
                        fr_d.sh   = fr_q.sh >> 1;
                        fr_d.left = fr_q.left - 4'd1;
                        fr_d.ones = fr_q.sh[0] ? fr_q.ones + 3'd1 : 3'd0;
                    end else if (avail) begin
                        pop       = 1'b1;
                        fr_d.tx   = head[0];
                        fr_d.sh   = head >> 1;
                        fr_d.left = 4'd7;
                        fr_d.ones = head[0] ? fr_q.ones + 3'd1 : 3'd0;
                    end else if (fr_q.eof) begin
                        fr_d.st    = S_IDLE;
                        fr_d.eof   = 1'b0;
                        fr_d.tx    = FLAG_BYTE[0];
                        fr_d.sh    = FLAG_BYTE >> 1;
                        fr_d.left  = 4'd7;
                        fr_d.ones  = '0;
                        fr_d.fl_ok = 1'b0;
                    end else begin
                        fr_d.st   = S_ABRT;
                        fr_d.urun = 1'b1;
                        fr_d.tx   = 1'b1;
                        fr_d.left = 4'(ABORT_ONES - 1);
                        fr_d.ones = '0;
                    end
                end
                S_ABRT: begin
                    fr_d.tx = 1'b1;
                    if (fr_q.left <= 4'd1) begin
                        fr_d.st    = S_IDLE;
                        fr_d.left  = 4'd0;
                        fr_d.fl_ok = 1'b0;
                    end else begin
                        fr_d.left = fr_q.left - 4'd1;
                    end
                end
                default: fr_d.st = S_IDLE;
            endcase
        end
        if (cmd_end && !cmd_reset) fr_d.eof = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q      <= '0;
            fr_q.st   <= S_IDLE;
            fr_q.tx   <= 1'b1;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign tx_bit   = fr_q.tx;
    assign underrun = fr_q.urun;

endmodule

// File: rtl/dch_frame_tx.sv
module dch_frame_tx #(
    parameter int DEPTH      = 32,
    parameter int ROOM_IRQ   = 16,
    parameter int ABORT_ONES = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       cmd_xmit,
    input  logic       cmd_end,
    input  logic       cmd_reset,
    output logic       tx_bit,
    output logic       pool_irq,
    output logic       underrun
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          pop;
    logic [7:0]    head;
    logic [CW-1:0] fifo_cnt;
    logic [CW-1:0] fifo_rel;
    logic          release_c;

    assign release_c = (cmd_xmit || cmd_end) && !cmd_reset;

    dtx_fifo #(
        .DEPTH (DEPTH),
        .ROOM  (ROOM_IRQ)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (cmd_reset),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .pop       (pop),
        .release_i (release_c),
        .head      (head),
        .cnt       (fifo_cnt),
        .rel       (fifo_rel),
        .room_ok   (pool_irq)
    );

    dtx_framer #(
        .ABORT_ONES (ABORT_ONES)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .cmd_end   (cmd_end),
        .cmd_reset (cmd_reset),
        .avail     (fifo_rel != '0),
        .head      (head),
        .pop       (pop),
        .tx_bit    (tx_bit),
        .underrun  (underrun)
    );

endmodule

// File: rtl/dtx_chk.sv
module dtx_chk #(
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_en,
    input logic          cmd_reset,
    input logic          tx_bit,
    input logic          underrun,
    input logic          pool_irq,
    input logic [CW-1:0] fifo_cnt,
    input logic [CW-1:0] fifo_rel
);
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit)); // R10

    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (fifo_cnt == '0 && fifo_rel == '0 && !underrun && pool_irq)); // R7

    AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !cmd_reset) |=> underrun); // R6

    AST_REL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rel <= fifo_cnt); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH)); // R9

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == CW'(DEPTH) && !bit_en && !cmd_reset) |=> fifo_cnt == CW'(DEPTH)); // R9

endmodule

bind dch_frame_tx dtx_chk #(
    .DEPTH (DEPTH),
    .CW    (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .cmd_reset (cmd_reset),
    .tx_bit    (tx_bit),
    .underrun  (underrun),
    .pool_irq  (pool_irq),
    .fifo_cnt  (fifo_cnt),
    .fifo_rel  (fifo_rel)
);

// File: tb/tb_dch_frame_tx.sv
module tb_dch_frame_tx;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cmd_xmit = 1'b0;
    logic       cmd_end = 1'b0;
    logic       cmd_reset = 1'b0;
    logic       tx_bit, pool_irq, underrun;

    dch_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wr_en(wr_en),
        .wr_data(wr_data), .cmd_xmit(cmd_xmit), .cmd_end(cmd_end),
        .cmd_reset(cmd_reset), .tx_bit(tx_bit), .pool_irq(pool_irq),
        .underrun(underrun)
    );

    always #(CLK_NS / 2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    // receiver model state
    int   ones = 0, nbits = 0, nframes = 0, naborts = 0, fstuff = 0;
    int   last_len = 0, last_stuff = 0;
    bit   inframe = 1'b0;
    logic fbits [4096];
    logic [7:0] lastb [64];
    logic [7:0] expb [64];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_frame(input int len);
        last_len   = len;
        last_stuff = fstuff;
        for (int i = 0; i < 64; i++) begin
            lastb[i] = '0;
            for (int k = 0; k < 8; k++)
                if (i * 8 + k < len) lastb[i][k] = fbits[i * 8 + k];
        end
        nframes++;
    endtask

    task automatic rx_bit(input logic b);
        if (b) begin
            ones++;
            if (ones == 7) begin
                naborts++;
                inframe = 1'b0;
                nbits = 0;
            end else if (inframe && ones < 7 && nbits < 4096) begin
                fbits[nbits] = 1'b1;
                nbits++;
            end
        end else begin
            if (ones == 6) begin
                if (inframe && nbits > 7) finish_frame(nbits - 7);
                inframe = 1'b1;
                nbits = 0;
                fstuff = 0;
            end else if (ones == 5) begin
                if (inframe) fstuff++;
            end else if (inframe && nbits < 4096) begin
                fbits[nbits] = 1'b0;
                nbits++;
            end
            ones = 0;
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) bit_en = 1'b1;
            @(negedge clk) bit_en = 1'b0;
            rx_bit(tx_bit);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk) begin wr_en = 1'b1; wr_data = v; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic pulse_xmit();
        @(negedge clk) cmd_xmit = 1'b1;
        @(negedge clk) cmd_xmit = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk) cmd_end = 1'b1;
        @(negedge clk) cmd_end = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk) cmd_reset = 1'b1;
        @(negedge clk) cmd_reset = 1'b0;
    endtask

    function automatic int stuff_count(input int n);
        int run = 0, s = 0;
        for (int i = 0; i < n; i++)
            for (int k = 0; k < 8; k++)
                if (expb[i][k]) begin
                    run++;
                    if (run == 5) begin s++; run = 0; end
                end else run = 0;
        return s;
    endfunction

    // compares the last decoded frame against expb[0..n-1]
    task automatic check_frame(input int n, input int frames_before);
        int bad = 0, first = -1;
        chk(nframes == frames_before + 1, "R3 frame count", nframes, frames_before + 1);
        chk(last_len == n * 8, "R3 frame length bits", last_len, n * 8);
        for (int i = 0; i < n; i++)
            if (lastb[i] !== expb[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (first < 0) chk(1'b1, "R3 bytes", 0, 0);
        else chk(1'b0, "R3 byte value", int'(lastb[first]), int'(expb[first]));
        chk(last_stuff == stuff_count(n), "R4 inserted zeros", last_stuff, stuff_count(n));
    endtask

    task automatic send_frame(input int n);
        int fb = nframes;
        for (int i = 0; i < n; i++) wr(expb[i]);
        pulse_end();
        step(n * 10 + 30);
        check_frame(n, fb);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int fb, ab;
        logic held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_bit == 1'b1, "R1 tx_bit", tx_bit, 1);
        chk(underrun == 1'b0, "R1 underrun", underrun, 0);
        chk(pool_irq == 1'b1, "R1 pool_irq", pool_irq, 1);

        // R2 idle flags, exact bit positions
        for (int k = 0; k < 32; k++) begin
            step(1);
            chk(tx_bit == (((k % 8) == 0 || (k % 8) == 7) ? 1'b0 : 1'b1),
                "R2 idle flag bit", tx_bit, ((k % 8) == 0 || (k % 8) == 7) ? 0 : 1);
        end

        // R10 hold without bit_en
        held = tx_bit;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            chk(tx_bit == held, "R10 hold", tx_bit, held);
        end

        // R3/R4 single-byte sweep over all values
        for (int v = 0; v < 256; v++) begin
            expb[0] = 8'(v);
            send_frame(1);
        end

        // R3/R4 multi-byte frames
        for (int len = 2; len <= 8; len++)
            for (int p = 0; p < 3; p++) begin
                for (int i = 0; i < len; i++)
                    expb[i] = (p == 0) ? 8'((i * 53 + len * 17) & 255) :
                              (p == 1) ? 8'hFF : 8'h7E;
                send_frame(len);
            end

        // R8 ready level while filling, R9 drop on full
        for (int k = 1; k <= 32; k++) begin
            expb[k - 1] = 8'((k * 29 + 3) & 255);
            wr(expb[k - 1]);
            chk(pool_irq == ((32 - k) >= 16), "R8 pool_irq", pool_irq, ((32 - k) >= 16) ? 1 : 0);
        end
        wr(8'hAB);
        chk(pool_irq == 1'b0, "R9 pool_irq full", pool_irq, 0);
        fb = nframes;
        pulse_end();
        step(32 * 10 + 30);
        check_frame(32, fb);   // R9: 33rd byte absent
        chk(pool_irq == 1'b1, "R8 pool_irq drained", pool_irq, 1);

        // R5 unreleased bytes are held; chunked continuation
        fb = nframes;
        ab = naborts;
        for (int i = 0; i < 4; i++) begin
            expb[i] = 8'(8'hC1 + 8'(i * 7));
            wr(expb[i]);
        end
        step(40);
        chk(nframes == fb, "R5 unreleased not sent frames", nframes, fb);
        chk(naborts == ab, "R5 unreleased not sent aborts", naborts, ab);
        pulse_xmit();
        step(12);
        for (int i = 4; i < 7; i++) begin
            expb[i] = 8'(8'h3C ^ 8'(i * 11));
            wr(expb[i]);
        end
        pulse_end();
        step(100);
        check_frame(7, fb);
        chk(naborts == ab, "R5 chunked no abort", naborts, ab);
        chk(underrun == 1'b0, "R5 no underrun", underrun, 0);

        // R6 underrun abort
        fb = nframes;
        ab = naborts;
        wr(8'h12);
        wr(8'h34);
        pulse_xmit();
        step(60);
        chk(naborts == ab + 1, "R6 abort seen", naborts, ab + 1);
        chk(nframes == fb, "R6 no frame", nframes, fb);
        chk(underrun == 1'b1, "R6 underrun set", underrun, 1);
        expb[0] = 8'hA5; expb[1] = 8'hFF; expb[2] = 8'h0F;
        send_frame(3);
        chk(underrun == 1'b1, "R6 underrun sticky", underrun, 1);

        // R7 reset command mid-frame
        fb = nframes;
        ab = naborts;
        for (int i = 0; i < 6; i++) wr(8'(8'h55 + 8'(i)));
        pulse_end();
        step(20);
        pulse_reset();
        chk(underrun == 1'b0, "R7 underrun cleared", underrun, 0);
        chk(pool_irq == 1'b1, "R7 store empty", pool_irq, 1);
        step(40);
        chk(naborts == ab + 1, "R7 abort seen", naborts, ab + 1);
        chk(nframes == fb, "R7 no frame", nframes, fb);
        pulse_end();
        step(60);
        chk(nframes == fb, "R7 flushed bytes not sent", nframes, fb);
        expb[0] = 8'h81; expb[1] = 8'h7E;
        send_frame(2);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule